// File: doc/BRIEF.md
# Row-Buffered Serial EEPROM Write Controller

This block sits behind a two-wire serial slave engine and turns one write transaction into a single timed programming cycle. The engine gives three kinds of single-cycle strobe: a word-address load that opens a transaction, a data-byte strobe for each received byte, and a stop strobe. The block gathers the data bytes in an eight-byte row latch and holds the 256 x 8 storage array. A programming cycle runs only when stop arrives. During that cycle the latched bytes go into the array and a busy flag stays high. The engine uses busy to withhold its acknowledge. Once busy falls, the device is addressable again, so a master can find the end of the write by acknowledge polling.

A mode input picks how the byte address advances. With the input high, multibyte mode applies: the full address increments, up to four bytes are taken, and those bytes may run into the next row. With the input low, page mode applies: only the three low address bits advance, so up to eight bytes land in one row. The base programming time is a parameter counted in clock cycles. A multibyte write whose bytes touch two rows takes twice that time. The array has a combinational read port for the read side of the engine.

Top module: `wc_row_writer`

## Requirements
- R1: After reset, busy is low and every array location reads 0xFF.
- R2: The mode is sampled at the address load. In multibyte mode (mode_multi = 1), byte k of a transaction (k counted from 0) goes to (start + (k mod 4)) mod 256. A fifth and later byte therefore overwrites earlier ones in the same sequence, and address 0xFF is followed by 0x00.
- R3: In page mode (mode_multi = 0), byte k goes to {start[7:3], (start[2:0] + k) mod 8}. Bytes past eight wrap inside the row and overwrite earlier ones.
- R4: Busy stays high for exactly WRITE_CYCLES clock cycles. The exception is a multibyte write where some written address has bits [7:3] different from the start address; that write holds busy for exactly 2 x WRITE_CYCLES cycles.
- R5: No array location changes before stop. A stop that ends a transaction with no data bytes starts no programming cycle, and busy stays low.
- R6: Busy rises in the cycle after the stop strobe. While busy is high, address-load, data and stop strobes have no effect, and no later cycle comes from them.
- R7: After busy falls, a new transaction is accepted and programmed normally.
- R8: A single-byte write gives the same array contents and the same busy time in either mode.
- R9: Data and stop strobes that arrive with no open transaction are ignored. A transaction is opened by an address load and closed by stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_multi | input | 1 | 1 = multibyte mode, 0 = page mode (sampled at address load) |
| addr_load | input | 1 | Strobe: open a transaction at addr_in |
| addr_in | input | 8 | Word address for addr_load |
| data_wr | input | 1 | Strobe: one received data byte |
| data_in | input | 8 | Data byte for data_wr |
| stop | input | 1 | Strobe: stop condition ends the transaction |
| rd_addr | input | 8 | Array read address |
| busy | output | 1 | Programming cycle in progress |
| rd_data | output | 8 | Array contents at rd_addr |

## Verification
The bench targets four kinds of fault:
- Address wrap. It overruns the byte limit in both modes and crosses from 0xFF to 0x00. A design that used the wrong wrap rule would write the neighbouring row, or would keep the first bytes that should have been overwritten.
- Programming time. It times busy on a write that stays in one row and on writes that cross a row. A design that failed to double the time, or doubled it in page mode, shows a busy length that does not match the reference.
- Stop handling. It checks a dummy address-only transaction, and it reads the array before stop. A design that started programming without data, or wrote bytes as they arrived, would change busy or the array contents too early.
- Lockout. It sends strobes during busy and checks the mode latch. A design that accepted traffic during busy, or read the mode per byte, would start a second cycle or write the wrong addresses.

// File: rtl/wc_pkg.sv
// Shared definitions for the row-buffered write controller.
// Assumes: none beyond the standard two-state encodings below.
package wc_pkg;
    // Write-mode encoding as seen on the mode input.
    typedef enum logic {
        WM_PAGE  = 1'b0,
        WM_MULTI = 1'b1
    } wmode_e;
endpackage

// File: rtl/wc_row_latch.sv
// Row latch: tracks one write transaction (start address, mode, byte count)
// and keeps the received bytes in slots indexed by the low address bits.
// It signals go at a stop that closes a transaction holding data, and
// presents one slot with its full array address to the commit sequencer.
// Assumes: MULTI_MAX is a power of two, 2 <= MULTI_MAX <= 2**ROW_W;
// the strobes are single-cycle; hold stays high during programming.
module wc_row_latch #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int ROW_W     = 3,
    parameter int MULTI_MAX = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              mode_multi,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_in,
    input  logic              stop,
    output logic              go,
    output logic              span,
    input  logic [ROW_W-1:0]  cidx,
    output logic [ADDR_W-1:0] caddr,
    output logic [DATA_W-1:0] cdata,
    output logic              cvalid
);
    import wc_pkg::*;

    localparam int ROW_BYTES = 1 << ROW_W;
    localparam int RADDR_W   = ADDR_W - ROW_W;
    localparam int MCNT_W    = $clog2(MULTI_MAX);

    logic [ADDR_W-1:0]  start_q;
    logic [ROW_W-1:0]   cnt_q;
    wmode_e             mode_q;
    logic               armed_q;
    logic               span_q;
    logic [ROW_BYTES-1:0] valid_q;
    logic [DATA_W-1:0]  data_q [ROW_BYTES];
    logic [ADDR_W-1:0]  tgt;
    logic [RADDR_W-1:0] start_row;
    logic [RADDR_W-1:0] crow;

    assign start_row = start_q[ADDR_W-1:ROW_W];

    // Target address of the next data byte under the active wrap rule.
    always_comb begin
        if (mode_q == WM_MULTI) begin
            tgt = start_q + ADDR_W'(cnt_q[MCNT_W-1:0]);
        end else begin
            tgt = {start_row, start_q[ROW_W-1:0] + cnt_q};
        end
    end

    // Start a program cycle only at a stop that closes a transaction with data.
    assign go = !hold && stop && !addr_load && !(data_wr && armed_q)
                && armed_q && (|valid_q);
    assign span = span_q;

    // Transaction tracking and byte capture, frozen while programming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            cnt_q   <= '0;
            mode_q  <= WM_MULTI;
            armed_q <= 1'b0;
            span_q  <= 1'b0;
            valid_q <= '0;
            for (int i = 0; i < ROW_BYTES; i++) begin
                data_q[i] <= '1;
            end
        end else if (!hold) begin
            if (addr_load) begin
                start_q <= addr_in;
                cnt_q   <= '0;
                mode_q  <= wmode_e'(mode_multi);
                armed_q <= 1'b1;
                span_q  <= 1'b0;
                valid_q <= '0;
            end else if (data_wr && armed_q) begin
                data_q[tgt[ROW_W-1:0]]  <= data_in;
                valid_q[tgt[ROW_W-1:0]] <= 1'b1;
                cnt_q <= cnt_q + 1'b1;
                if (mode_q == WM_MULTI && tgt[ADDR_W-1:ROW_W] != start_row) begin
                    span_q <= 1'b1;
                end
            end else if (stop) begin
                armed_q <= 1'b0;
            end
        end
    end

    // Slot-to-address map: in multibyte mode, slots below the start offset lie in the next row.
    always_comb begin
        if (mode_q == WM_MULTI && cidx < start_q[ROW_W-1:0]) begin
            crow = start_row + RADDR_W'(1);
        end else begin
            crow = start_row;
        end
    end

    assign caddr  = {crow, cidx};
    assign cdata  = data_q[cidx];
    assign cvalid = valid_q[cidx];
endmodule

// File: rtl/wc_prog_timer.sv
// Programming timer: holds busy for WRITE_CYCLES cycles, or twice that when
// span is set at go, and steps a slot index over the first row-size cycles
// so that the latch can be copied into the array.
// Assumes: WRITE_CYCLES >= 2**ROW_W so the copy ends before busy falls.
module wc_prog_timer #(
    parameter int WRITE_CYCLES = 40,
    parameter int ROW_W        = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             span,
    output logic             busy,
    output logic [ROW_W-1:0] slot_idx,
    output logic             slot_en
);
    localparam int ROW_BYTES = 1 << ROW_W;
    localparam int CNT_W     = $clog2(2 * WRITE_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit_q;
    logic             busy_q;

    // Cycle counter and busy flag for one programming cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            limit_q <= '0;
            busy_q  <= 1'b0;
        end else if (go && !busy_q) begin
            cnt_q   <= '0;
            limit_q <= span ? CNT_W'(2 * WRITE_CYCLES) : CNT_W'(WRITE_CYCLES);
            busy_q  <= 1'b1;
        end else if (busy_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == limit_q - CNT_W'(1)) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign busy     = busy_q;
    assign slot_idx = cnt_q[ROW_W-1:0];
    assign slot_en  = busy_q && (cnt_q < CNT_W'(ROW_BYTES));
endmodule

// File: rtl/wc_store.sv
// Storage array: one synchronous write port and one combinational read port.
// Every location is set to all ones on reset.
// Assumes: 2**ADDR_W stays small enough to be held in flops.
module wc_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Array update: erased state on reset, one byte per write enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '1;
            end
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/wc_row_writer.sv
// Top of the row-buffered write controller. It takes transaction strobes
// from the serial engine, latches up to one row of bytes, and at stop runs
// a self-timed program cycle that copies the latch into the array.
// Busy stays high for the whole cycle, and during it every strobe is ignored.
// Assumes: strobes are single-cycle pulses, and the engine withholds its
// acknowledge while busy is high.
module wc_row_writer #(
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = 8,
    parameter int ROW_W        = 3,
    parameter int MULTI_MAX    = 4,
    parameter int WRITE_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_multi,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_in,
    input  logic              stop,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output logic [DATA_W-1:0] rd_data
);
    logic              go;
    logic              span;
    logic [ROW_W-1:0]  slot_idx;
    logic              slot_en;
    logic [ADDR_W-1:0] caddr;
    logic [DATA_W-1:0] cdata;
    logic              cvalid;
    logic              mem_we;

    wc_row_latch #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROW_W(ROW_W), .MULTI_MAX(MULTI_MAX)
    ) u_latch (
        .clk(clk), .rst_n(rst_n), .hold(busy), .mode_multi(mode_multi),
        .addr_load(addr_load), .addr_in(addr_in), .data_wr(data_wr),
        .data_in(data_in), .stop(stop), .go(go), .span(span),
        .cidx(slot_idx), .caddr(caddr), .cdata(cdata), .cvalid(cvalid)
    );

    wc_prog_timer #(
        .WRITE_CYCLES(WRITE_CYCLES), .ROW_W(ROW_W)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .go(go), .span(span), .busy(busy),
        .slot_idx(slot_idx), .slot_en(slot_en)
    );

    // Copy only the slots that the transaction filled.
    assign mem_we = slot_en && cvalid;

    wc_store #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(caddr), .wdata(cdata),
        .raddr(rd_addr), .rdata(rd_data)
    );
endmodule

// File: rtl/wc_row_writer_chk.sv
// Checker for wc_row_writer: relates busy, the go request and array writes
// over time. Busy length is measured with a counter, not a long $past.
module wc_row_writer_chk #(
    parameter int WRITE_CYCLES = 40
) (
    input logic clk,
    input logic rst_n,
    input logic stop,
    input logic busy,
    input logic go,
    input logic span,
    input logic mem_we
);
    logic [31:0] run_q;
    logic        span_seen_q;

    // Length of the current busy run and the span class that started it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q       <= '0;
            span_seen_q <= 1'b0;
        end else begin
            run_q <= busy ? run_q + 32'd1 : 32'd0;
            if (go) span_seen_q <= span;
        end
    end

    // R1: busy is low right after reset.
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !busy);

    // R4: the busy run ends at the base time, or at twice it for a spanning write.
    a_r4_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == (span_seen_q ? 32'(2 * WRITE_CYCLES) : 32'(WRITE_CYCLES))));

    // R5: a programming cycle begins only after a stop strobe.
    a_r5_start_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop));

    // R5: the array is written only inside a programming cycle.
    a_r5_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R6: a request to program is raised only while idle, and busy follows it.
    a_r6_no_go_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !go);
    a_r6_busy_follows_go: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> busy);
endmodule

bind wc_row_writer wc_row_writer_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .stop(stop), .busy(busy), .go(go),
    .span(span), .mem_we(mem_we)
);

// File: tb/wc_row_writer_bench.sv
`timescale 1ns/1ps
// Bench for wc_row_writer: a behavioural reference (queues, integers)
// follows every strobe and is compared with busy on each clock and with
// the array contents whenever it is idle.
module wc_row_writer_bench;
    localparam int TW = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_multi = 1'b1;
    logic       addr_load = 1'b0;
    logic [7:0] addr_in = '0;
    logic       data_wr = 1'b0;
    logic [7:0] data_in = '0;
    logic       stop = 1'b0;
    logic [7:0] rd_addr = '0;
    logic       busy;
    logic [7:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Reference model state
    int m_ref [256];
    int m_left = 0;
    bit m_armed = 0;
    bit m_mode = 1;
    int m_start = 0;
    int m_k = 0;
    int pa[$];
    int pd[$];

    always #5 clk = ~clk;

    wc_row_writer #(.WRITE_CYCLES(TW)) u_wc_row_writer (
        .clk(clk), .rst_n(rst_n), .mode_multi(mode_multi), .addr_load(addr_load),
        .addr_in(addr_in), .data_wr(data_wr), .data_in(data_in), .stop(stop),
        .rd_addr(rd_addr), .busy(busy), .rd_data(rd_data)
    );

    // Reference: transaction tracking, wrap rules and timed commit.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_left = 0; m_armed = 0;
            for (int i = 0; i < 256; i++) m_ref[i] = 255;
        end else if (m_left > 0) begin
            m_left = m_left - 1;
            if (m_left == 0) begin
                for (int i = 0; i < pa.size(); i++) m_ref[pa[i]] = pd[i];
            end
        end else if (addr_load) begin
            m_start = addr_in; m_k = 0; m_mode = mode_multi; m_armed = 1;
            pa.delete(); pd.delete();
        end else if (data_wr && m_armed) begin
            if (m_mode) pa.push_back((m_start + (m_k % 4)) % 256);
            else pa.push_back((m_start & 248) | ((m_start + m_k) & 7));
            pd.push_back(data_in);
            m_k = m_k + 1;
        end else if (stop && m_armed) begin
            bit sp;
            m_armed = 0;
            sp = 0;
            foreach (pa[i]) if ((pa[i] >> 3) != (m_start >> 3)) sp = 1;
            if (pa.size() > 0) m_left = sp ? 2 * TW : TW;
        end
    end

    // R4 R6: busy matches the reference on every clock.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (busy !== (m_left > 0)) begin
                failures++;
                $display("FAIL R4/R6 busy at %0t: actual=%0b expected=%0b", $time, busy, m_left > 0);
            end
        end
    end

    task automatic pulse_addr(input bit md, input int a);
        @(negedge clk); mode_multi = md; addr_in = 8'(a); addr_load = 1'b1;
        @(negedge clk); addr_load = 1'b0;
    endtask

    task automatic pulse_data(input int d);
        @(negedge clk); data_in = 8'(d); data_wr = 1'b1;
        @(negedge clk); data_wr = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
    endtask

    task automatic wait_idle();
        while (m_left > 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic scan(input string tag);
        int bad = 0;
        for (int a = 0; a < 256; a++) begin
            @(negedge clk); rd_addr = 8'(a);
            #1;
            if (rd_data !== 8'(m_ref[a])) begin
                bad++;
                $display("FAIL %s mem[%0d]: actual=%0h expected=%0h", tag, a, rd_data, m_ref[a]);
            end
        end
        checks++;
        if (bad != 0) failures++;
    endtask

    task automatic check_busy_low(input string tag);
        checks++;
        if (busy !== 1'b0) begin
            failures++;
            $display("FAIL %s busy: actual=%0b expected=0", tag, busy);
        end
    endtask

    task automatic write_txn(input bit md, input int a, input int n, input int seed);
        pulse_addr(md, a);
        for (int i = 0; i < n; i++) pulse_data((seed + 17 * i) & 255);
        pulse_stop();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_busy_low("R1");
        scan("R1");

        // R8: single byte in each mode
        write_txn(1'b1, 16, 1, 8'h3C); wait_idle(); scan("R8 multi single");
        write_txn(1'b0, 34, 1, 8'h3D); wait_idle(); scan("R8 page single");

        // R2 R4: four bytes from 0x05 cross into the next row (double time)
        write_txn(1'b1, 5, 4, 8'h11); wait_idle(); scan("R2 R4 cross");
        // R2: six bytes wrap back to the start of the sequence
        write_txn(1'b1, 64, 6, 8'h21); wait_idle(); scan("R2 overrun");
        // R3: ten bytes in page mode wrap inside the row
        write_txn(1'b0, 93, 10, 8'h41); wait_idle(); scan("R3 page wrap");
        // R3 R4: full page from mid-row, no time doubling
        write_txn(1'b0, 124, 8, 8'h51); wait_idle(); scan("R3 page full");
        // R2 R4: 0xFF then 0x00
        write_txn(1'b1, 255, 2, 8'h61); wait_idle(); scan("R2 top wrap");

        // R5: bytes not in the array before stop
        pulse_addr(1'b1, 160); pulse_data(8'h77); pulse_data(8'h78);
        repeat (3) @(negedge clk);
        scan("R5 before stop");
        pulse_stop(); wait_idle(); scan("R5 after stop");

        // R5: address-only transaction starts nothing
        pulse_addr(1'b0, 200); pulse_stop();
        repeat (2) @(negedge clk);
        check_busy_low("R5 dummy");

        // R6: strobes during busy ignored; R7: accepted afterwards
        pulse_addr(1'b1, 8); pulse_data(8'h99); pulse_stop();
        pulse_addr(1'b1, 48); pulse_data(8'hAA); pulse_stop();
        wait_idle();
        check_busy_low("R6 no second cycle");
        scan("R6 ignored");
        write_txn(1'b1, 48, 3, 8'hB0); wait_idle(); scan("R7 after poll");

        // R9: data and stop without an open transaction
        pulse_data(8'hCC); pulse_stop();
        repeat (2) @(negedge clk);
        check_busy_low("R9 no txn");
        scan("R9 ignored");

        // R2: mode taken at address load (page) even if it changes later
        pulse_addr(1'b0, 134);
        mode_multi = 1'b1;
        for (int i = 0; i < 4; i++) pulse_data(8'hD0 + i);
        pulse_stop(); wait_idle(); scan("R2 mode sampled");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule